// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard controller for a five-stage in-order integer pipeline (Fetch, Decode, Execute, Memory, Writeback). Each cycle it looks at the two source register numbers of the instruction in Decode and at the destination descriptors of the instructions in Execute and Memory. From these it drives the pipeline-register controls: holds for the program counter and the Fetch/Decode register, a bubble into the Decode/Execute register, and flushes of the three younger stages when a branch resolves taken in Memory.

The forwarding mux selects for the two Execute operands are decided one stage early. While an instruction sits in Decode, the unit works out which older instruction will be one stage or two stages ahead of it once it enters Execute. It registers that choice on the same edge that moves the instruction forward. The compare logic is therefore off the Execute-stage path. The selects are cleared whenever the Decode/Execute register receives a bubble or a flush.

A load reaches Execute and is followed by a consumer in Decode that reads its destination. The unit then stalls for exactly one cycle, and the consumer later takes the loaded value from Writeback. Register 0 is hardwired to zero and never causes forwarding or stalls.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While reset (active-low, synchronous) is asserted, and on the first cycle after it is released, `fwd_a_sel` and `fwd_b_sel` are 2'b00, whatever the inputs show.
- R2: Select encoding: 2'b00 = register-file value, 2'b01 = result held in Memory, 2'b10 = result held in Writeback; 2'b11 never appears. Suppose that at a clock edge a Decode source matches no non-zero destination of a writing Execute or Memory instruction. After that edge, its select (`fwd_a_sel` for the first source, `fwd_b_sel` for the second) is 2'b00.
- R3: Take a non-zero Decode source that equals `exe_rd` of a writing, non-load Execute instruction, where no stall and no flush occur. After the edge its select is 2'b01.
- R4: Take a non-zero Decode source that equals `mem_rd` of a writing Memory instruction, with no non-load writing Execute match. After the edge its select is 2'b10, and the same holds when the Memory instruction is a load.
- R5: When a source matches both the Execute and the Memory destination, the Execute match (the younger producer) wins, giving 2'b01 after the edge.
- R6: A Decode source equal to register 0 yields select 2'b00 after the edge and never raises a stall.
- R7: Load-use stall: `hold_pc`, `hold_fd` and `bubble_de` are all 1 in the same cycle exactly when `exe_load` and `exe_wr` are 1. In that cycle `exe_rd` must be non-zero and equal `dec_rs` or `dec_rt`, and `mem_br_taken` must be 0; otherwise all three are 0.
- R8: On the edge at which a bubble is inserted, both selects become 2'b00. When the held consumer then moves to Execute, with the load one stage ahead in Memory, its select is 2'b10, so the loaded value comes from Writeback.
- R9: `flush_fd`, `flush_de` and `flush_em` equal `mem_br_taken` in the same cycle, and both selects are 2'b00 after an edge at which a flush was requested.
- R10: A taken branch overrides a load-use stall: with `mem_br_taken` high, `hold_pc`, `hold_fd` and `bubble_de` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_rs | input | REG_AW | First source register of the instruction in Decode |
| dec_rt | input | REG_AW | Second source register of the instruction in Decode |
| exe_rd | input | REG_AW | Destination register of the instruction in Execute |
| exe_wr | input | 1 | Instruction in Execute writes a register |
| exe_load | input | 1 | Instruction in Execute is a load |
| mem_rd | input | REG_AW | Destination register of the instruction in Memory |
| mem_wr | input | 1 | Instruction in Memory writes a register |
| mem_br_taken | input | 1 | Branch in Memory resolved taken |
| fwd_a_sel | output | 2 | Operand A source select for the Execute stage |
| fwd_b_sel | output | 2 | Operand B source select for the Execute stage |
| hold_pc | output | 1 | Keep the program counter unchanged |
| hold_fd | output | 1 | Keep the Fetch/Decode register unchanged |
| bubble_de | output | 1 | Load a no-write, no-store instruction into Decode/Execute |
| flush_fd | output | 1 | Squash the instruction entering Decode |
| flush_de | output | 1 | Squash the instruction entering Execute |
| flush_em | output | 1 | Squash the instruction entering Memory |

## Verification
The checker's properties ask nothing of the inputs. They relate the stall, bubble and flush outputs of one cycle to the selects of the next, and these relations must hold for any descriptor combination. This includes combinations a real pipeline never produces, such as a writing instruction in Execute on the cycle after a bubble. The stimulus therefore sweeps every combination of a 2-bit register-number configuration freely. It does not restrict itself to legal instruction streams. The one-stall-then-Writeback sequence is additionally driven as a short, consistent stage-by-stage scenario.

// File: rtl/hzd_pkg.sv
// Package: shared types for the pipeline hazard controller.
// Assumes the Execute operand muxes decode the 2-bit select below.
package hzd_pkg;

    // Number of register sources per instruction that may need forwarding.
    localparam int NUM_SRC = 2;

    // Operand source select seen by the Execute-stage muxes.
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_MEM = 2'b01,
        FWD_WB  = 2'b10
    } fwd_sel_t;

endpackage

// File: rtl/hzd_fwd_pick.sv
// Module: decides, for one Decode source, where its operand must come from
// once the instruction reaches Execute. The instruction now in Execute will
// then be in Memory, and the one now in Memory will be in Writeback.
// Assumes register 0 reads as zero and a load result is not usable from
// Memory (the load-use stall covers that case).
module hzd_fwd_pick
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wr,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wr,
    output fwd_sel_t          nxt_sel
);

    logic src_live;
    logic hit_ex;
    logic hit_mem;

    // Match detection against the two older in-flight writers.
    always_comb begin
        src_live = (src != '0);
        hit_ex   = src_live && ex_wr && !ex_load && (ex_rd == src);
        hit_mem  = src_live && mem_wr && (mem_rd == src);
    end

    // Priority: the younger producer (now in Execute) wins.
    always_comb begin
        if (hit_ex) begin
            nxt_sel = FWD_MEM;
        end else if (hit_mem) begin
            nxt_sel = FWD_WB;
        end else begin
            nxt_sel = FWD_RF;
        end
    end

endmodule

// File: rtl/hzd_loaduse.sv
// Module: flags a load in Execute whose destination is read by the
// instruction in Decode. One generate branch per source register.
// Assumes exe_load is only meaningful together with exe_wr.
module hzd_loaduse
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [NUM_SRC-1:0][REG_AW-1:0] src,
    input  logic [REG_AW-1:0]              ex_rd,
    input  logic                           ex_wr,
    input  logic                           ex_load,
    output logic                           hit
);

    logic [NUM_SRC-1:0] src_hit;
    logic               ld_live;

    // A load that actually writes a non-zero register.
    assign ld_live = ex_load && ex_wr && (ex_rd != '0);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        // Per-source dependence on the load destination.
        assign src_hit[g] = ld_live && (src[g] == ex_rd);
    end

    assign hit = |src_hit;

endmodule

// File: rtl/hzd_squash.sv
// Module: turns the load-use flag and the branch outcome into pipeline
// register controls. A taken branch (resolved in Memory) squashes Fetch,
// Decode and Execute and overrides any stall in the same cycle.
// Assumes a bubble is formed downstream by clearing write and store flags.
module hzd_squash (
    input  logic ld_hit,
    input  logic br_taken,
    output logic hold_pc,
    output logic hold_fd,
    output logic bubble_de,
    output logic flush_fd,
    output logic flush_de,
    output logic flush_em,
    output logic kill_ex
);

    logic stall;

    // Stall only when no flush is pending.
    assign stall = ld_hit && !br_taken;

    // Drive the pipeline register controls.
    always_comb begin
        hold_pc   = stall;
        hold_fd   = stall;
        bubble_de = stall;
        flush_fd  = br_taken;
        flush_de  = br_taken;
        flush_em  = br_taken;
        kill_ex   = stall || br_taken;
    end

endmodule

// File: rtl/pipe_hazard_ctl.sv
// Module: hazard and forwarding controller for a five-stage in-order pipeline.
// Forwarding selects are computed while the instruction is in Decode and
// registered on the edge that moves it into Execute; they drop to the
// register-file choice whenever Decode/Execute receives a bubble or flush.
// Assumes the datapath honours hold, bubble and flush on the same edge.
module pipe_hazard_ctl
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] dec_rs,
    input  logic [REG_AW-1:0] dec_rt,
    input  logic [REG_AW-1:0] exe_rd,
    input  logic              exe_wr,
    input  logic              exe_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wr,
    input  logic              mem_br_taken,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic              hold_pc,
    output logic              hold_fd,
    output logic              bubble_de,
    output logic              flush_fd,
    output logic              flush_de,
    output logic              flush_em
);

    logic [NUM_SRC-1:0][REG_AW-1:0] dec_src;
    logic                           ld_hit;
    logic                           kill_ex;

    assign dec_src = {dec_rt, dec_rs};

    hzd_loaduse #(
        .REG_AW (REG_AW)
    ) u_loaduse (
        .src     (dec_src),
        .ex_rd   (exe_rd),
        .ex_wr   (exe_wr),
        .ex_load (exe_load),
        .hit     (ld_hit)
    );

    hzd_squash u_squash (
        .ld_hit    (ld_hit),
        .br_taken  (mem_br_taken),
        .hold_pc   (hold_pc),
        .hold_fd   (hold_fd),
        .bubble_de (bubble_de),
        .flush_fd  (flush_fd),
        .flush_de  (flush_de),
        .flush_em  (flush_em),
        .kill_ex   (kill_ex)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
        fwd_sel_t nxt_sel;
        fwd_sel_t sel_q;

        hzd_fwd_pick #(
            .REG_AW (REG_AW)
        ) u_pick (
            .src     (dec_src[g]),
            .ex_rd   (exe_rd),
            .ex_wr   (exe_wr),
            .ex_load (exe_load),
            .mem_rd  (mem_rd),
            .mem_wr  (mem_wr),
            .nxt_sel (nxt_sel)
        );

        // Capture the select for the instruction entering Execute.
        always_ff @(posedge clk) begin
            if (!rst_n || kill_ex) begin
                sel_q <= FWD_RF;
            end else begin
                sel_q <= nxt_sel;
            end
        end
    end

    assign fwd_a_sel = g_op[0].sel_q;
    assign fwd_b_sel = g_op[1].sel_q;

endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
// Module: property checker for pipe_hazard_ctl, attached with bind.
// Assumes nothing about the stage descriptors.
module pipe_hazard_ctl_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] dec_rs,
    input logic [REG_AW-1:0] dec_rt,
    input logic              exe_wr,
    input logic              exe_load,
    input logic              mem_br_taken,
    input logic [1:0]        fwd_a_sel,
    input logic [1:0]        fwd_b_sel,
    input logic              hold_pc,
    input logic              hold_fd,
    input logic              bubble_de,
    input logic              flush_de
);

    // R2
    sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));

    // R6
    zero_rs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_rs == '0) |=> (fwd_a_sel == 2'b00));

    // R6
    zero_rt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_rt == '0) |=> (fwd_b_sel == 2'b00));

    // R7
    stall_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_pc |-> (exe_load && exe_wr && hold_fd));

    // R8
    bubble_clears_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_de |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));

    // R9
    flush_clears_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_de |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));

    // R10
    flush_beats_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_br_taken |-> (!hold_pc && !hold_fd && !bubble_de));

endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(
    .REG_AW (REG_AW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_rs       (dec_rs),
    .dec_rt       (dec_rt),
    .exe_wr       (exe_wr),
    .exe_load     (exe_load),
    .mem_br_taken (mem_br_taken),
    .fwd_a_sel    (fwd_a_sel),
    .fwd_b_sel    (fwd_b_sel),
    .hold_pc      (hold_pc),
    .hold_fd      (hold_fd),
    .bubble_de    (bubble_de),
    .flush_de     (flush_de)
);

// File: tb/pipe_hazard_ctl_bench.sv
// Bench: exhaustive sweep of all descriptor combinations with 2-bit
// register numbers, plus a directed load-use sequence.
module pipe_hazard_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 2;
    localparam int SWEEP_N    = 1 << (4 * AW + 4);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] dec_rs = '0, dec_rt = '0, exe_rd = '0, mem_rd = '0;
    logic          exe_wr = 1'b0, exe_load = 1'b0, mem_wr = 1'b0, mem_br_taken = 1'b0;
    logic [1:0]    fwd_a_sel, fwd_b_sel;
    logic          hold_pc, hold_fd, bubble_de, flush_fd, flush_de, flush_em;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pipe_hazard_ctl #(.REG_AW(AW)) u_pipe_hazard_ctl (
        .clk(clk), .rst_n(rst_n), .dec_rs(dec_rs), .dec_rt(dec_rt),
        .exe_rd(exe_rd), .exe_wr(exe_wr), .exe_load(exe_load),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_br_taken(mem_br_taken),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .hold_pc(hold_pc),
        .hold_fd(hold_fd), .bubble_de(bubble_de), .flush_fd(flush_fd),
        .flush_de(flush_de), .flush_em(flush_em)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected select from the requirement rules R2..R6.
    function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
        if (s == '0) return 2'b00;
        if (exe_wr && !exe_load && exe_rd == s) return 2'b01;
        if (mem_wr && mem_rd == s) return 2'b10;
        return 2'b00;
    endfunction

    function automatic string sel_tag(input logic [AW-1:0] s, input logic kill);
        if (kill) return mem_br_taken ? "R9" : "R8";
        if (s == '0) return "R6";
        if (exe_wr && !exe_load && exe_rd == s && mem_wr && mem_rd == s) return "R5";
        if (exe_wr && !exe_load && exe_rd == s) return "R3";
        if (mem_wr && mem_rd == s) return "R4";
        return "R2";
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        logic [1:0] ea, eb;
        string      ta, tb;
        logic       st, kill;
        // Reset with inputs that would otherwise forward from Memory.
        dec_rs = 2'd1; exe_rd = 2'd1; exe_wr = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 fwd_a in reset", {6'd0, fwd_a_sel}, 8'd0);
        chk("R1 fwd_b in reset", {6'd0, fwd_b_sel}, 8'd0);
        rst_n = 1'b1;
        dec_rs = '0; exe_rd = '0; exe_wr = 1'b0;
        ea = 2'b00; eb = 2'b00; ta = "R1"; tb = "R1";
        for (int i = 0; i < SWEEP_N; i++) begin
            @(negedge clk);
            chk({ta, " fwd_a"}, {6'd0, fwd_a_sel}, {6'd0, ea});
            chk({tb, " fwd_b"}, {6'd0, fwd_b_sel}, {6'd0, eb});
            {mem_br_taken, mem_wr, mem_rd, exe_load, exe_wr, exe_rd, dec_rt, dec_rs} = i[4*AW+3:0];
            #1;
            st = exe_load && exe_wr && exe_rd != '0 &&
                 (dec_rs == exe_rd || dec_rt == exe_rd) && !mem_br_taken;
            chk(mem_br_taken ? "R10 hold_pc" : "R7 hold_pc", {7'd0, hold_pc}, {7'd0, st});
            chk(mem_br_taken ? "R10 hold_fd" : "R7 hold_fd", {7'd0, hold_fd}, {7'd0, st});
            chk(mem_br_taken ? "R10 bubble" : "R7 bubble", {7'd0, bubble_de}, {7'd0, st});
            chk("R9 flushes", {5'd0, flush_fd, flush_de, flush_em}, {5'd0, {3{mem_br_taken}}});
            kill = st || mem_br_taken;
            ea = kill ? 2'b00 : exp_sel(dec_rs);
            eb = kill ? 2'b00 : exp_sel(dec_rt);
            ta = sel_tag(dec_rs, kill);
            tb = sel_tag(dec_rt, kill);
        end
        @(negedge clk);
        chk({ta, " fwd_a"}, {6'd0, fwd_a_sel}, {6'd0, ea});
        chk({tb, " fwd_b"}, {6'd0, fwd_b_sel}, {6'd0, eb});
        // Directed R8: load r3 in Execute, consumer reads r3 in Decode.
        {mem_br_taken, mem_wr, mem_rd} = '0;
        exe_rd = 2'd3; exe_wr = 1'b1; exe_load = 1'b1; dec_rs = 2'd2; dec_rt = 2'd3;
        #1;
        chk("R8 stall raised", {7'd0, bubble_de}, 8'd1);
        @(negedge clk);
        chk("R8 fwd_b after bubble", {6'd0, fwd_b_sel}, 8'd0);
        // Bubble now in Execute, load in Memory, consumer still in Decode.
        exe_rd = '0; exe_wr = 1'b0; exe_load = 1'b0; mem_rd = 2'd3; mem_wr = 1'b1;
        #1;
        chk("R8 single stall", {7'd0, hold_pc}, 8'd0);
        @(negedge clk);
        chk("R8 fwd_b from writeback", {6'd0, fwd_b_sel}, 8'd2);
        chk("R8 fwd_a untouched", {6'd0, fwd_a_sel}, 8'd0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule